// File: doc/BRIEF.md
# Event Counter Freeze Control

This block pairs a 32-bit monitor control register with two 32-bit event counters. On every clock cycle the control register, the current privilege level of the processor and a per-process mark bit together decide whether the hardware may advance the counters. Each counter watches its own bus of event pulses. A select field in the control register picks which single event line that counter follows.

Software reaches the block through a simple register port. A privilege flag comes with every access. The control register and both counters can be written only by a supervisor access. A user-level access gets a read-only view of the control value at a separate alias address. Any other user access is refused and is reported by a one-cycle violation pulse. Five freeze conditions can each stop counting on its own: an unconditional freeze, one freeze for each privilege level, and one freeze for each level of the process mark.

Top module: `perfmon_gate`

## Requirements
- R1: While `rst` is high at a clock edge, the control register, both counters and `priv_err` are all zero after that edge.
- R2: A supervisor write (`acc_priv`=1) to address 0 loads the control register at the next edge. Reads at address 0 return the control value and leave it unchanged, however many reads are made.
- R3: Address map: 0 is control, 1 is counter A, 2 is counter B, 3 is the control alias. A user access (`acc_priv`=0) to addresses 0 to 2 has no effect, and a read of those addresses returns zero. A write to address 3 has no effect in either mode, and a read of address 3 returns the control value in either mode. Each refused access makes `priv_err` high for exactly the one cycle after the access edge.
- R4: Counter A's select field is control bits [12:6]; counter B's is bits [5:0] (bit 0 is the LSB). A select value k from 1 to `EVT_W` makes the counter add 1 at each edge where event line k-1 of its bus is high and counting is enabled. Other event lines are ignored.
- R5: A select value of 0, or one greater than `EVT_W`, keeps the counter still whatever events arrive. A freshly reset block therefore counts nothing.
- R6: Control bit 31 set stops both counters unconditionally.
- R7: Control bit 30 stops both counters while `user_mode`=0 (supervisor). Control bit 29 stops them while `user_mode`=1.
- R8: Control bit 28 stops both counters while `proc_mark`=1. Control bit 27 stops them while `proc_mark`=0.
- R9: An event that arrives while counting is stopped is lost. It is not counted later, after the freeze ends.
- R10: A counter at 0xFFFFFFFF wraps to 0 on its next counted event.
- R11: A supervisor write to a counter in the same cycle as a counted event loads the written value, and that event adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = supervisor access, 0 = user access |
| acc_addr | input | 2 | Register address (see R3) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational from the address |
| user_mode | input | 1 | Processor privilege: 1 = user, 0 = supervisor |
| proc_mark | input | 1 | Per-process mark bit |
| evt_a | input | EVT_W | Event pulses that counter A can select |
| evt_b | input | EVT_W | Event pulses that counter B can select |
| ctrl_q | output | 32 | Current control register |
| cnt_a | output | 32 | Counter A value |
| cnt_b | output | 32 | Counter B value |
| priv_err | output | 1 | One-cycle pulse after a refused access |

## Verification
The counters are driven with the selected event line high and with only an unselected line high. This separates correct event routing from counting on any activity. Each of the five freeze bits is exercised against both levels of the input it depends on. A bit wired to the wrong polarity, or to the wrong input, therefore shows up as a stopped counter where counting was expected, or the reverse. Event bursts during a freeze followed by an idle period tell a dropped event from a deferred one. A write and an event in the same cycle, and a counter held at all ones, cover the write priority and the wrap.

// File: rtl/pmon_pkg.sv
package pmon_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    // freeze bit positions (LSB = bit 0)
    localparam int FRZ_ALL_BIT = 31;
    localparam int FRZ_SUP_BIT = 30;
    localparam int FRZ_USR_BIT = 29;
    localparam int FRZ_MK1_BIT = 28;
    localparam int FRZ_MK0_BIT = 27;
    localparam int FRZ_N       = 5;

    // event select fields
    localparam int SEL_A_LSB = 6;
    localparam int SEL_A_W   = 7;
    localparam int SEL_B_LSB = 0;
    localparam int SEL_B_W   = 6;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL       = 2'd0,
        ADDR_CNT_A      = 2'd1,
        ADDR_CNT_B      = 2'd2,
        ADDR_CTRL_ALIAS = 2'd3
    } pmon_addr_e;

    typedef struct packed {
        logic all;
        logic sup;
        logic usr;
        logic mark_hi;
        logic mark_lo;
    } freeze_t;

    typedef struct packed {
        logic              en;
        logic              wr;
        logic              priv;
        pmon_addr_e        addr;
        logic [DATA_W-1:0] wdata;
    } acc_req_t;

    typedef struct packed {
        logic ctrl_wr;
        logic cnt_a_wr;
        logic cnt_b_wr;
        logic refused;
    } acc_dec_t;

    // slice [4]=bit31 ... [0]=bit27
    function automatic freeze_t unpack_freeze(input logic [FRZ_N-1:0] bits);
        freeze_t f;
        f.all     = bits[FRZ_ALL_BIT-FRZ_MK0_BIT];
        f.sup     = bits[FRZ_SUP_BIT-FRZ_MK0_BIT];
        f.usr     = bits[FRZ_USR_BIT-FRZ_MK0_BIT];
        f.mark_hi = bits[FRZ_MK1_BIT-FRZ_MK0_BIT];
        f.mark_lo = bits[0];
        return f;
    endfunction

    function automatic acc_dec_t decode_access(input acc_req_t r);
        acc_dec_t d;
        logic     priv_ok;
        logic     alias_hit;
        alias_hit  = (r.addr == ADDR_CTRL_ALIAS);
        priv_ok    = r.priv && !alias_hit;
        d.ctrl_wr  = r.en && r.wr && priv_ok && (r.addr == ADDR_CTRL);
        d.cnt_a_wr = r.en && r.wr && priv_ok && (r.addr == ADDR_CNT_A);
        d.cnt_b_wr = r.en && r.wr && priv_ok && (r.addr == ADDR_CNT_B);
        d.refused  = r.en && ((r.wr && !priv_ok) || (!r.wr && !r.priv && !alias_hit));
        return d;
    endfunction

endpackage

// File: rtl/pmon_ctrl_reg.sv
module pmon_ctrl_reg
    import pmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_req_t          req,
    output logic [DATA_W-1:0] ctrl,
    output logic              wr_cnt_a,
    output logic              wr_cnt_b,
    output logic              priv_err
);
    acc_dec_t dec;

    always_comb dec = decode_access(req);

    assign wr_cnt_a = dec.cnt_a_wr;
    assign wr_cnt_b = dec.cnt_b_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            priv_err <= 1'b0;
        end else begin
            if (dec.ctrl_wr) ctrl <= req.wdata;
            priv_err <= dec.refused;
        end
    end
endmodule

// File: rtl/pmon_freeze.sv
module pmon_freeze
    import pmon_pkg::*;
(
    input  freeze_t frz,
    input  logic    user_mode,
    input  logic    proc_mark,
    output logic    count_en
);
    logic [FRZ_N-1:0] cause;

    always_comb begin
        cause[0] = frz.all;
        cause[1] = frz.sup && !user_mode;
        cause[2] = frz.usr && user_mode;
        cause[3] = frz.mark_hi && proc_mark;
        cause[4] = frz.mark_lo && !proc_mark;
        count_en = ~|cause;
    end
endmodule

// File: rtl/pmon_counter.sv
module pmon_counter
    import pmon_pkg::*;
#(
    parameter int SEL_W = 6,
    parameter int EVT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              count_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [EVT_W-1:0]  evts,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt
);
    logic [EVT_W-1:0] match;
    logic             hit;

    // select k in 1..EVT_W follows line k-1; anything else matches nothing
    for (genvar k = 0; k < EVT_W; k++) begin : g_match
        assign match[k] = (sel == SEL_W'(k + 1)) && evts[k];
    end

    assign hit = |match;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_en) begin
            cnt <= wdata;
        end else if (count_en && hit) begin
            cnt <= cnt + DATA_W'(1);
        end
    end
endmodule

// File: rtl/perfmon_gate.sv
module perfmon_gate
    import pmon_pkg::*;
#(
    parameter int EVT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_priv,
    input  logic [1:0]        acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    input  logic              user_mode,
    input  logic              proc_mark,
    input  logic [EVT_W-1:0]  evt_a,
    input  logic [EVT_W-1:0]  evt_b,
    output logic [31:0]       ctrl_q,
    output logic [31:0]       cnt_a,
    output logic [31:0]       cnt_b,
    output logic              priv_err
);
    acc_req_t          req;
    freeze_t           frz;
    logic              count_en;
    logic              wr_a;
    logic              wr_b;
    logic [DATA_W-1:0] ctrl;

    always_comb begin
        req.en    = acc_en;
        req.wr    = acc_wr;
        req.priv  = acc_priv;
        req.addr  = pmon_addr_e'(acc_addr);
        req.wdata = acc_wdata;
    end

    pmon_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .ctrl     (ctrl),
        .wr_cnt_a (wr_a),
        .wr_cnt_b (wr_b),
        .priv_err (priv_err)
    );

    assign frz = unpack_freeze(ctrl[FRZ_ALL_BIT:FRZ_MK0_BIT]);

    pmon_freeze u_frz (
        .frz       (frz),
        .user_mode (user_mode),
        .proc_mark (proc_mark),
        .count_en  (count_en)
    );

    pmon_counter #(.SEL_W(SEL_A_W), .EVT_W(EVT_W)) u_cnt_a (
        .clk      (clk),
        .rst      (rst),
        .count_en (count_en),
        .sel      (ctrl[SEL_A_LSB +: SEL_A_W]),
        .evts     (evt_a),
        .wr_en    (wr_a),
        .wdata    (acc_wdata),
        .cnt      (cnt_a)
    );

    pmon_counter #(.SEL_W(SEL_B_W), .EVT_W(EVT_W)) u_cnt_b (
        .clk      (clk),
        .rst      (rst),
        .count_en (count_en),
        .sel      (ctrl[SEL_B_LSB +: SEL_B_W]),
        .evts     (evt_b),
        .wr_en    (wr_b),
        .wdata    (acc_wdata),
        .cnt      (cnt_b)
    );

    assign ctrl_q = ctrl;

    always_comb begin
        acc_rdata = '0;
        if (acc_en && !acc_wr) begin
            unique case (req.addr)
                ADDR_CTRL_ALIAS: acc_rdata = ctrl;
                ADDR_CTRL:       acc_rdata = acc_priv ? ctrl  : '0;
                ADDR_CNT_A:      acc_rdata = acc_priv ? cnt_a : '0;
                ADDR_CNT_B:      acc_rdata = acc_priv ? cnt_b : '0;
                default:         acc_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/perfmon_gate_chk.sv
module perfmon_gate_chk (
    input logic        clk,
    input logic        rst,
    input logic        acc_en,
    input logic        acc_wr,
    input logic        acc_priv,
    input logic [1:0]  acc_addr,
    input logic [31:0] acc_wdata,
    input logic [31:0] ctrl_q,
    input logic [31:0] cnt_a,
    input logic [31:0] cnt_b,
    input logic        priv_err
);
    logic sup_wr_a;
    logic sup_wr_b;
    logic user_wr;

    assign sup_wr_a = acc_en && acc_wr && acc_priv && (acc_addr == 2'd1);
    assign sup_wr_b = acc_en && acc_wr && acc_priv && (acc_addr == 2'd2);
    assign user_wr  = acc_en && acc_wr && !acc_priv;

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (ctrl_q == 32'd0 && cnt_a == 32'd0 && cnt_b == 32'd0 && !priv_err));

    // R3
    a_r3_user_write_ignored: assert property (@(posedge clk) disable iff (rst)
        user_wr |=> ($stable(ctrl_q) && priv_err));

    // R4
    a_r4_step_by_one: assert property (@(posedge clk) disable iff (rst)
        !sup_wr_a |=> (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + 32'd1));

    // R5
    a_r5_sel_zero_still: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[5:0] == 6'd0 && !sup_wr_b) |=> $stable(cnt_b));

    // R6
    a_r6_freeze_all: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[31] && !sup_wr_a && !sup_wr_b) |=> ($stable(cnt_a) && $stable(cnt_b)));

    // R11
    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        sup_wr_a |=> (cnt_a == $past(acc_wdata)));
endmodule

bind perfmon_gate perfmon_gate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_priv  (acc_priv),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .ctrl_q    (ctrl_q),
    .cnt_a     (cnt_a),
    .cnt_b     (cnt_b),
    .priv_err  (priv_err)
);

// File: tb/perfmon_gate_tb.sv
module perfmon_gate_tb;
    localparam int EVT_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             acc_en, acc_wr, acc_priv;
    logic [1:0]       acc_addr;
    logic [31:0]      acc_wdata, acc_rdata;
    logic             user_mode, proc_mark;
    logic [EVT_W-1:0] evt_a, evt_b;
    logic [31:0]      ctrl_q, cnt_a, cnt_b;
    logic             priv_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    perfmon_gate #(.EVT_W(EVT_W)) u_dut (
        .clk(clk), .rst(rst),
        .acc_en(acc_en), .acc_wr(acc_wr), .acc_priv(acc_priv),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .user_mode(user_mode), .proc_mark(proc_mark),
        .evt_a(evt_a), .evt_b(evt_b),
        .ctrl_q(ctrl_q), .cnt_a(cnt_a), .cnt_b(cnt_b), .priv_err(priv_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_bus();
        acc_en = 1'b0; acc_wr = 1'b0; acc_priv = 1'b0;
        acc_addr = 2'd0; acc_wdata = '0;
    endtask

    task automatic sup_write(input logic [1:0] a, input logic [31:0] d);
        acc_en = 1'b1; acc_wr = 1'b1; acc_priv = 1'b1; acc_addr = a; acc_wdata = d;
        cyc();
        idle_bus();
    endtask

    task automatic pulse(input logic [EVT_W-1:0] ea, input logic [EVT_W-1:0] eb, input int n);
        evt_a = ea; evt_b = eb;
        for (int i = 0; i < n; i++) cyc();
        evt_a = '0; evt_b = '0;
    endtask

    // A and B count with sel 1 and 2 plus extra freeze bits
    task automatic set_ctrl(input logic [31:0] frz_bits);
        sup_write(2'd0, frz_bits | 32'h0000_0042);
    endtask

    task automatic t_reset();
        check("R1 ctrl", ctrl_q, 32'd0);
        check("R1 cnt_a", cnt_a, 32'd0);
        check("R1 cnt_b", cnt_b, 32'd0);
        check("R1 priv_err", {31'd0, priv_err}, 32'd0);
        pulse('1, '1, 3);
        check("R5 reset sel zero A", cnt_a, 32'd0);
        check("R5 reset sel zero B", cnt_b, 32'd0);
    endtask

    task automatic t_ctrl_rw();
        set_ctrl(32'd0);
        check("R2 ctrl written", ctrl_q, 32'h42);
        for (int i = 0; i < 2; i++) begin
            acc_en = 1'b1; acc_wr = 1'b0; acc_priv = 1'b1; acc_addr = 2'd0;
            #1 check("R2 read value", acc_rdata, 32'h42);
            cyc();
            idle_bus();
        end
        check("R2 read no side effect", ctrl_q, 32'h42);
    endtask

    task automatic t_count();
        logic [31:0] a0, b0;
        user_mode = 1'b0; proc_mark = 1'b0;
        a0 = cnt_a; b0 = cnt_b;
        pulse(8'b0000_0001, 8'b0000_0010, 3);
        check("R4 A counts line 0", cnt_a, a0 + 3);
        check("R4 B counts line 1", cnt_b, b0 + 3);
        pulse(8'b1111_1110, 8'b1111_1101, 2);
        check("R4 A ignores other lines", cnt_a, a0 + 3);
        check("R4 B ignores other lines", cnt_b, b0 + 3);
    endtask

    task automatic t_sel_range();
        logic [31:0] a0;
        sup_write(2'd0, 32'h0000_0240);   // A sel 9, B sel 0
        a0 = cnt_a;
        pulse('1, '1, 3);
        check("R5 A sel beyond range", cnt_a, a0);
        sup_write(2'd0, 32'h0000_0200);   // A sel 8
        pulse(8'b1000_0000, 8'h00, 1);
        check("R4 A sel 8 follows line 7", cnt_a, a0 + 1);
    endtask

    task automatic t_freeze_all_drop();
        logic [31:0] a0, b0;
        set_ctrl(32'h8000_0000);
        a0 = cnt_a; b0 = cnt_b;
        pulse(8'h01, 8'h02, 3);
        check("R6 A frozen", cnt_a, a0);
        check("R6 B frozen", cnt_b, b0);
        set_ctrl(32'd0);
        cyc(); cyc();
        check("R9 no deferred count", cnt_a, a0);
        pulse(8'h01, 8'h00, 1);
        check("R9 counts after unfreeze", cnt_a, a0 + 1);
    endtask

    task automatic freeze_case(input string req, input logic [31:0] bitv,
                               input logic um, input logic mk, input logic expect_cnt);
        logic [31:0] a0;
        set_ctrl(bitv);
        user_mode = um; proc_mark = mk;
        a0 = cnt_a;
        pulse(8'h01, 8'h00, 1);
        check(req, cnt_a, expect_cnt ? a0 + 1 : a0);
        user_mode = 1'b0; proc_mark = 1'b0;
    endtask

    task automatic t_freeze_mode();
        freeze_case("R7 bit30 sup frozen",  32'h4000_0000, 1'b0, 1'b0, 1'b0);
        freeze_case("R7 bit30 user counts", 32'h4000_0000, 1'b1, 1'b0, 1'b1);
        freeze_case("R7 bit29 user frozen", 32'h2000_0000, 1'b1, 1'b0, 1'b0);
        freeze_case("R7 bit29 sup counts",  32'h2000_0000, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_freeze_mark();
        freeze_case("R8 bit28 mark1 frozen", 32'h1000_0000, 1'b0, 1'b1, 1'b0);
        freeze_case("R8 bit28 mark0 counts", 32'h1000_0000, 1'b0, 1'b0, 1'b1);
        freeze_case("R8 bit27 mark0 frozen", 32'h0800_0000, 1'b0, 1'b0, 1'b0);
        freeze_case("R8 bit27 mark1 counts", 32'h0800_0000, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_user_access();
        logic [31:0] c0, a0;
        set_ctrl(32'd0);
        c0 = ctrl_q; a0 = cnt_a;
        acc_en = 1'b1; acc_wr = 1'b1; acc_priv = 1'b0; acc_addr = 2'd0; acc_wdata = 32'hFFFF_FFFF;
        cyc();
        check("R3 violation pulse", {31'd0, priv_err}, 32'd1);
        idle_bus();
        cyc();
        check("R3 pulse one cycle", {31'd0, priv_err}, 32'd0);
        check("R3 user write ignored", ctrl_q, c0);
        acc_en = 1'b1; acc_wr = 1'b1; acc_priv = 1'b0; acc_addr = 2'd1; acc_wdata = 32'h1234;
        cyc();
        idle_bus();
        check("R3 user counter write ignored", cnt_a, a0);
        acc_en = 1'b1; acc_wr = 1'b0; acc_priv = 1'b0; acc_addr = 2'd3;
        #1 check("R3 user alias read", acc_rdata, c0);
        acc_addr = 2'd1;
        #1 check("R3 user counter read zero", acc_rdata, 32'd0);
        cyc();
        idle_bus();
        check("R3 user read refused", {31'd0, priv_err}, 32'd1);
        acc_en = 1'b1; acc_wr = 1'b1; acc_priv = 1'b1; acc_addr = 2'd3; acc_wdata = 32'h8000_0000;
        cyc();
        idle_bus();
        check("R3 alias write ignored", ctrl_q, c0);
        check("R3 alias write refused", {31'd0, priv_err}, 32'd1);
        cyc();
    endtask

    task automatic t_wrap_priority();
        set_ctrl(32'd0);
        sup_write(2'd1, 32'hFFFF_FFFF);
        check("R11 counter written", cnt_a, 32'hFFFF_FFFF);
        pulse(8'h01, 8'h00, 1);
        check("R10 wrap to zero", cnt_a, 32'd0);
        evt_a = 8'h01;
        sup_write(2'd1, 32'h0000_0100);
        evt_a = '0;
        check("R11 write beats event", cnt_a, 32'h0000_0100);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle_bus();
        user_mode = 1'b0; proc_mark = 1'b0;
        evt_a = '0; evt_b = '0;
        rst = 1'b1;
        @(negedge clk);
        cyc(); cyc();
        rst = 1'b0;
        t_reset();
        t_ctrl_rw();
        t_count();
        t_sel_range();
        t_freeze_all_drop();
        t_freeze_mode();
        t_freeze_mark();
        t_user_access();
        t_wrap_priority();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule